// File: doc/BRIEF.md
# Tagged Circular Register Stack

This block holds eight 64-bit floating-point values in a ring of physical slots. A 3-bit top pointer wraps around the ring, and every command names its operand relative to that pointer. Each slot carries an occupancy tag. The tags decide whether a command is legal. An illegal command reports one of two faults: the slot is empty, or the slot is full. A faulting command leaves the stack exactly as it was.

Commands arrive as an opcode, a relative index and a data word, qualified by `cmd_valid`. The block accepts one command on every clock, so `cmd_ready` stays high. Each accepted command produces one registered response on the following cycle. The response carries the data read, the tag of the addressed slot as it was before the command, and the two fault flags. The pointer is always visible as a 32-bit word.

Reset leaves the stack with every tag empty and the pointer at zero. The initialise command does the same, but it keeps the stored values.

Top module: `regstack_top`

## Requirements
- R1: After reset, and after an initialise command (opcode 7), every tag is empty and the pointer is 0. Initialise leaves the stored values unchanged and never faults.
- R2: Push (opcode 0) targets slot (ptr-1) mod 8. If that slot is empty, the pointer becomes (ptr-1) mod 8, `cmd_data` is stored there and its tag is set. If that slot is occupied, the command raises the full fault instead.
- R3: Pop (opcode 1) returns the value in slot ptr, clears that slot's tag and sets the pointer to (ptr+1) mod 8. If slot ptr is empty, the command raises the empty fault instead.
- R4: A relative index i selects physical slot (ptr+i) mod 8. Read (opcode 2) returns that slot's value, or raises the empty fault if the slot is empty.
- R5: Modify (opcode 3) returns the old value of slot (ptr+i) and stores `cmd_data` there. It raises the empty fault if the slot is empty, and it never raises the full fault.
- R6: Write (opcode 4) stores `cmd_data` in slot (ptr+i) and sets its tag. It raises the full fault if the slot is already occupied.
- R7: Examine (opcode 5) returns the value of slot (ptr+i) in any tag state and never raises a fault.
- R8: Copy-from-top (opcode 6) copies the value of slot ptr into slot (ptr+i), sets the destination tag and returns the copied value. It never raises the full fault. It raises the empty fault if slot ptr is empty.
- R9: A faulting command changes no value, no tag and not the pointer. Its response data is 0.
- R10: The response comes one cycle after acceptance, with `rsp_valid` high for that one cycle. A fault flag is only ever high together with `rsp_valid`, and at most one of the two flags is high. `cmd_ready` is 1 outside reset.
- R11: `ptr_word` carries the pointer in bits 2:0, and bits 31:3 read as 0.
- R12: `rsp_tag` reports the tag, as it was before the command, of the slot the command targets. For copy-from-top this is the destination slot, and for initialise it is 0. Response data is 0 for push, write and initialise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 3 | Opcode (0 push, 1 pop, 2 read, 3 modify, 4 write, 5 examine, 6 copy-from-top, 7 initialise) |
| cmd_idx | input | 3 | Relative stack index |
| cmd_data | input | 64 | Value for push, modify and write |
| rsp_valid | output | 1 | Response present, one cycle per command |
| rsp_data | output | 64 | Value read, or 0 |
| rsp_tag | output | 1 | Pre-command tag of the targeted slot |
| rsp_empty_fault | output | 1 | Targeted or source slot was empty |
| rsp_full_fault | output | 1 | Write target was occupied |
| ptr_word | output | 32 | Top pointer, zero-extended |

## Verification
A command is taken at a rising edge. Its response fields, the new tags and the new `ptr_word` all become visible right after that same edge. The bench therefore drives each command on a falling edge and lets exactly one rising edge pass. It then reads every result at the following falling edge, and it drops `cmd_valid` there so that `rsp_valid` can be seen falling one cycle later. Any effect a faulting or exempt command might have had on stored state is looked for through later read and examine responses.

// File: rtl/regstack_pkg.sv
package regstack_pkg;
  localparam int unsigned STK_DATA_W    = 64;
  localparam int unsigned STK_DEPTH     = 8;
  localparam int unsigned STK_PTRWORD_W = 32;

  typedef enum logic [2:0] {
    OP_PUSH    = 3'd0,
    OP_POP     = 3'd1,
    OP_READ    = 3'd2,
    OP_MODIFY  = 3'd3,
    OP_WRITE   = 3'd4,
    OP_EXAMINE = 3'd5,
    OP_COPY0   = 3'd6,
    OP_INIT    = 3'd7
  } op_e;
endpackage

// File: rtl/regstack_decode.sv
module regstack_decode
  import regstack_pkg::*;
#(
  parameter int unsigned DEPTH = STK_DEPTH
) (
  input  op_e                        op,
  input  logic [$clog2(DEPTH)-1:0]   idx,
  input  logic [$clog2(DEPTH)-1:0]   top,
  input  logic [DEPTH-1:0]           tags,
  output logic [$clog2(DEPTH)-1:0]   tgt_slot,
  output logic [$clog2(DEPTH)-1:0]   src_slot,
  output logic [$clog2(DEPTH)-1:0]   top_nxt,
  output logic                       rd_en,
  output logic                       wr_en,
  output logic                       clr_en,
  output logic                       init_en,
  output logic                       empty_flt,
  output logic                       full_flt
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  logic [PTR_W-1:0] rel_slot;
  assign rel_slot = top + idx;

  always_comb begin
    tgt_slot  = rel_slot;
    src_slot  = rel_slot;
    top_nxt   = top;
    rd_en     = 1'b0;
    wr_en     = 1'b0;
    clr_en    = 1'b0;
    init_en   = 1'b0;
    empty_flt = 1'b0;
    full_flt  = 1'b0;
    unique case (op)
      OP_PUSH: begin
        tgt_slot = top - ONE;
        src_slot = top - ONE;
        full_flt = tags[top - ONE];
        wr_en    = 1'b1;
        top_nxt  = top - ONE;
      end
      OP_POP: begin
        tgt_slot  = top;
        src_slot  = top;
        empty_flt = ~tags[top];
        rd_en     = 1'b1;
        clr_en    = 1'b1;
        top_nxt   = top + ONE;
      end
      OP_READ: begin
        empty_flt = ~tags[rel_slot];
        rd_en     = 1'b1;
      end
      OP_MODIFY: begin
        empty_flt = ~tags[rel_slot];
        rd_en     = 1'b1;
        wr_en     = 1'b1;
      end
      OP_WRITE: begin
        full_flt = tags[rel_slot];
        wr_en    = 1'b1;
      end
      OP_EXAMINE: begin
        rd_en = 1'b1;
      end
      OP_COPY0: begin
        src_slot  = top;
        empty_flt = ~tags[top];
        rd_en     = 1'b1;
        wr_en     = 1'b1;
      end
      OP_INIT: begin
        init_en = 1'b1;
        top_nxt = '0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/regstack_file.sv
module regstack_file
  import regstack_pkg::*;
#(
  parameter int unsigned DATA_W = STK_DATA_W,
  parameter int unsigned DEPTH  = STK_DEPTH
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       clr_en,
  input  logic                       init_en,
  input  logic [$clog2(DEPTH)-1:0]   acc_slot,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [$clog2(DEPTH)-1:0]   rd_slot,
  output logic [DATA_W-1:0]          rd_data,
  output logic [DEPTH-1:0]           tags
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic [DEPTH-1:0][DATA_W-1:0] mem;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic              hit;
    logic              tag_en;
    logic              tag_d;
    logic              tag_q;
    logic [DATA_W-1:0] data_q;

    assign hit = (acc_slot == PTR_W'(g));

    always_comb begin
      tag_en = init_en | (hit & (wr_en | clr_en));
      tag_d  = ~init_en & hit & wr_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              data_q <= '0;
      else if (hit && wr_en)   data_q <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tag_q <= 1'b0;
      else if (tag_en) tag_q <= tag_d;
    end

    assign mem[g]  = data_q;
    assign tags[g] = tag_q;
  end

  assign rd_data = mem[rd_slot];
endmodule

// File: rtl/regstack_top.sv
module regstack_top
  import regstack_pkg::*;
#(
  parameter int unsigned DATA_W    = STK_DATA_W,
  parameter int unsigned DEPTH     = STK_DEPTH,
  parameter int unsigned PTRWORD_W = STK_PTRWORD_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic [2:0]               cmd_op,
  input  logic [$clog2(DEPTH)-1:0] cmd_idx,
  input  logic [DATA_W-1:0]        cmd_data,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_data,
  output logic                     rsp_tag,
  output logic                     rsp_empty_fault,
  output logic                     rsp_full_fault,
  output logic [PTRWORD_W-1:0]     ptr_word
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  op_e              op;
  logic [PTR_W-1:0] top_q, top_d, top_nxt;
  logic [PTR_W-1:0] tgt_slot, src_slot;
  logic             rd_en, wr_en, clr_en, init_en, empty_flt, full_flt;
  logic             accept, commit, fault;
  logic [DEPTH-1:0] tags;
  logic [DATA_W-1:0] rd_data, wr_data;

  logic              vld_q, vld_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic              tag_q, tag_d;
  logic              ef_q, ef_d, ff_q, ff_d;

  assign op        = op_e'(cmd_op);
  assign cmd_ready = 1'b1;
  assign accept    = cmd_valid & cmd_ready;
  assign fault     = empty_flt | full_flt;
  assign commit    = accept & ~fault;

  regstack_decode #(.DEPTH(DEPTH)) u_decode (
    .op        (op),
    .idx       (cmd_idx),
    .top       (top_q),
    .tags      (tags),
    .tgt_slot  (tgt_slot),
    .src_slot  (src_slot),
    .top_nxt   (top_nxt),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .clr_en    (clr_en),
    .init_en   (init_en),
    .empty_flt (empty_flt),
    .full_flt  (full_flt)
  );

  assign wr_data = (op == OP_COPY0) ? rd_data : cmd_data;

  regstack_file #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_file (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (commit & wr_en),
    .clr_en   (commit & clr_en),
    .init_en  (commit & init_en),
    .acc_slot (tgt_slot),
    .wr_data  (wr_data),
    .rd_slot  (src_slot),
    .rd_data  (rd_data),
    .tags     (tags)
  );

  always_comb begin
    top_d = top_nxt;
    vld_d = accept;
    ef_d  = accept & empty_flt;
    ff_d  = accept & full_flt;
    dat_d = (rd_en && !fault) ? rd_data : '0;
    tag_d = init_en ? 1'b0 : tags[tgt_slot];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      top_q <= '0;
    else if (commit) top_q <= top_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      ef_q  <= 1'b0;
      ff_q  <= 1'b0;
    end else begin
      vld_q <= vld_d;
      ef_q  <= ef_d;
      ff_q  <= ff_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
      tag_q <= 1'b0;
    end else if (accept) begin
      dat_q <= dat_d;
      tag_q <= tag_d;
    end
  end

  assign rsp_valid       = vld_q;
  assign rsp_data        = dat_q;
  assign rsp_tag         = tag_q;
  assign rsp_empty_fault = ef_q;
  assign rsp_full_fault  = ff_q;
  assign ptr_word        = {{(PTRWORD_W-PTR_W){1'b0}}, top_q};
endmodule

// File: rtl/regstack_chk.sv
module regstack_chk
  import regstack_pkg::*;
#(
  parameter int unsigned DEPTH     = STK_DEPTH,
  parameter int unsigned PTRWORD_W = STK_PTRWORD_W
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmd_valid,
  input logic                 cmd_ready,
  input logic [2:0]           cmd_op,
  input logic                 rsp_valid,
  input logic                 rsp_empty_fault,
  input logic                 rsp_full_fault,
  input logic [PTRWORD_W-1:0] ptr_word,
  input logic [DEPTH-1:0]     tags
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic acc;
  assign acc = cmd_valid & cmd_ready;

  // R10
  fault_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_empty_fault || rsp_full_fault) |-> rsp_valid);

  // R10
  one_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_empty_fault, rsp_full_fault}));

  // R10
  rsp_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);

  // R10
  no_rsp_without_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !rsp_valid);

  // R9
  fault_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_empty_fault || rsp_full_fault)) |-> (ptr_word == $past(ptr_word)));

  // R9
  fault_keeps_tags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_empty_fault || rsp_full_fault)) |-> (tags == $past(tags)));

  // R2
  push_moves_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc && cmd_op == OP_PUSH) && rsp_valid && !rsp_full_fault)
      |-> (ptr_word[PTR_W-1:0] == PTR_W'($past(ptr_word[PTR_W-1:0]) - 1'b1)));

  // R3
  pop_moves_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc && cmd_op == OP_POP) && rsp_valid && !rsp_empty_fault)
      |-> (ptr_word[PTR_W-1:0] == PTR_W'($past(ptr_word[PTR_W-1:0]) + 1'b1)));

  // R7
  examine_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc && cmd_op == OP_EXAMINE) && rsp_valid) |-> !(rsp_empty_fault || rsp_full_fault));

  // R5
  modify_no_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc && cmd_op == OP_MODIFY) && rsp_valid) |-> !rsp_full_fault);

  // R8
  copy_no_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc && cmd_op == OP_COPY0) && rsp_valid) |-> !rsp_full_fault);

  // R1
  init_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc && cmd_op == OP_INIT) && rsp_valid)
      |-> (tags == '0 && ptr_word == '0 && !rsp_empty_fault && !rsp_full_fault));
endmodule

bind regstack_top regstack_chk #(.DEPTH(DEPTH), .PTRWORD_W(PTRWORD_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cmd_valid       (cmd_valid),
  .cmd_ready       (cmd_ready),
  .cmd_op          (cmd_op),
  .rsp_valid       (rsp_valid),
  .rsp_empty_fault (rsp_empty_fault),
  .rsp_full_fault  (rsp_full_fault),
  .ptr_word        (ptr_word),
  .tags            (tags)
);

// File: tb/regstack_top_bench.sv
`timescale 1ns/1ps
module regstack_top_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [2:0]  cmd_op;
  logic [2:0]  cmd_idx;
  logic [63:0] cmd_data;
  logic        rsp_valid;
  logic [63:0] rsp_data;
  logic        rsp_tag;
  logic        rsp_empty_fault;
  logic        rsp_full_fault;
  logic [31:0] ptr_word;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  regstack_top u_regstack_top (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_idx(cmd_idx), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_tag(rsp_tag),
    .rsp_empty_fault(rsp_empty_fault), .rsp_full_fault(rsp_full_fault),
    .ptr_word(ptr_word)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [2:0]  idx;
    logic [63:0] din;
    logic [63:0] dout;
    logic        ef;
    logic        ff;
    logic        tag;
    logic [31:0] ptr;
  } vec_t;

  localparam logic [63:0] VA = 64'hA000_0000_0000_0001;
  localparam logic [63:0] VB = 64'hB000_0000_0000_0002;
  localparam logic [63:0] VC = 64'hC000_0000_0000_0003;
  localparam logic [63:0] VD = 64'hD000_0000_0000_0004;
  localparam logic [63:0] VE = 64'hE000_0000_0000_0005;
  localparam logic [63:0] VF = 64'hF000_0000_0000_0006;
  localparam logic [63:0] VG = 64'h9000_0000_0000_0007;
  localparam int NVEC = 27;

  localparam vec_t VECS [NVEC] = '{
    '{3'd2, 3'd0, 64'd0, 64'd0, 1'b1, 1'b0, 1'b0, 32'd0},
    '{3'd0, 3'd0, VA,    64'd0, 1'b0, 1'b0, 1'b0, 32'd7},
    '{3'd0, 3'd0, VB,    64'd0, 1'b0, 1'b0, 1'b0, 32'd6},
    '{3'd2, 3'd0, 64'd0, VB,    1'b0, 1'b0, 1'b1, 32'd6},
    '{3'd2, 3'd1, 64'd0, VA,    1'b0, 1'b0, 1'b1, 32'd6},
    '{3'd2, 3'd2, 64'd0, 64'd0, 1'b1, 1'b0, 1'b0, 32'd6},
    '{3'd5, 3'd2, 64'd0, 64'd0, 1'b0, 1'b0, 1'b0, 32'd6},
    '{3'd4, 3'd1, VC,    64'd0, 1'b0, 1'b1, 1'b1, 32'd6},
    '{3'd2, 3'd1, 64'd0, VA,    1'b0, 1'b0, 1'b1, 32'd6},
    '{3'd4, 3'd2, VC,    64'd0, 1'b0, 1'b0, 1'b0, 32'd6},
    '{3'd2, 3'd2, 64'd0, VC,    1'b0, 1'b0, 1'b1, 32'd6},
    '{3'd3, 3'd0, VD,    VB,    1'b0, 1'b0, 1'b1, 32'd6},
    '{3'd2, 3'd0, 64'd0, VD,    1'b0, 1'b0, 1'b1, 32'd6},
    '{3'd3, 3'd3, VE,    64'd0, 1'b1, 1'b0, 1'b0, 32'd6},
    '{3'd5, 3'd3, 64'd0, 64'd0, 1'b0, 1'b0, 1'b0, 32'd6},
    '{3'd6, 3'd1, 64'd0, VD,    1'b0, 1'b0, 1'b1, 32'd6},
    '{3'd2, 3'd1, 64'd0, VD,    1'b0, 1'b0, 1'b1, 32'd6},
    '{3'd1, 3'd0, 64'd0, VD,    1'b0, 1'b0, 1'b1, 32'd7},
    '{3'd1, 3'd0, 64'd0, VD,    1'b0, 1'b0, 1'b1, 32'd0},
    '{3'd1, 3'd0, 64'd0, VC,    1'b0, 1'b0, 1'b1, 32'd1},
    '{3'd1, 3'd0, 64'd0, 64'd0, 1'b1, 1'b0, 1'b0, 32'd1},
    '{3'd0, 3'd0, VF,    64'd0, 1'b0, 1'b0, 1'b0, 32'd0},
    '{3'd0, 3'd0, VG,    64'd0, 1'b0, 1'b0, 1'b0, 32'd7},
    '{3'd5, 3'd0, 64'd0, VG,    1'b0, 1'b0, 1'b1, 32'd7},
    '{3'd7, 3'd0, 64'd0, 64'd0, 1'b0, 1'b0, 1'b0, 32'd0},
    '{3'd2, 3'd0, 64'd0, 64'd0, 1'b1, 1'b0, 1'b0, 32'd0},
    '{3'd5, 3'd7, 64'd0, VG,    1'b0, 1'b0, 1'b0, 32'd0}
  };

  function automatic string op_req(input logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R1";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // Drive at a falling edge, let one rising edge take it, read at the next falling edge.
  task automatic issue(input logic [2:0] op, input logic [2:0] idx, input logic [63:0] din);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_idx   = idx;
    cmd_data  = din;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    cmd_valid = 1'b0;
    cmd_op    = 3'd0;
    cmd_idx   = 3'd0;
    cmd_data  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R10 R11: state after reset
    check("R10", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
    check("R10", "cmd_ready", 64'(cmd_ready), 64'd1);
    check("R1", "ptr after reset", 64'(ptr_word), 64'd0);

    // table walk
    for (int k = 0; k < NVEC; k++) begin
      issue(VECS[k].op, VECS[k].idx, VECS[k].din);
      check("R10", $sformatf("vec %0d valid", k), 64'(rsp_valid), 64'd1);
      check(op_req(VECS[k].op), $sformatf("vec %0d data", k), rsp_data, VECS[k].dout);
      check(VECS[k].ef ? "R9" : op_req(VECS[k].op), $sformatf("vec %0d empty", k),
            64'(rsp_empty_fault), 64'(VECS[k].ef));
      check(VECS[k].ff ? "R9" : op_req(VECS[k].op), $sformatf("vec %0d full", k),
            64'(rsp_full_fault), 64'(VECS[k].ff));
      check("R12", $sformatf("vec %0d tag", k), 64'(rsp_tag), 64'(VECS[k].tag));
      check("R11", $sformatf("vec %0d ptr", k), 64'(ptr_word), 64'(VECS[k].ptr));
    end

    // R10: response lasts one cycle only
    @(negedge clk);
    check("R10", "valid drops after one cycle", 64'(rsp_valid), 64'd0);

    // R2: fill all eight slots, pointer wraps down to 0, ninth push is full
    issue(3'd7, 3'd0, 64'd0);
    for (int k = 0; k < 8; k++) begin
      issue(3'd0, 3'd0, 64'h100 + 64'(k));
      check("R2", $sformatf("fill %0d ptr", k), 64'(ptr_word), 64'(7 - k));
    end
    issue(3'd0, 3'd0, 64'hDEAD);
    check("R2", "push on full slot faults", 64'(rsp_full_fault), 64'd1);
    check("R9", "faulted push keeps ptr", 64'(ptr_word), 64'd0);
    // R4: relative index walks the ring
    for (int i = 0; i < 8; i++) begin
      issue(3'd2, 3'(i), 64'd0);
      check("R4", $sformatf("read st(%0d)", i), rsp_data, 64'h100 + 64'(7 - i));
    end

    // R8: copy-from-top with empty source faults
    issue(3'd7, 3'd0, 64'd0);
    issue(3'd6, 3'd1, 64'd0);
    check("R8", "copy from empty top faults", 64'(rsp_empty_fault), 64'd1);
    issue(3'd5, 3'd1, 64'd0);
    check("R9", "copy fault left tag clear", 64'(rsp_tag), 64'd0);

    // R1: asynchronous reset in mid run
    issue(3'd0, 3'd0, VA);
    check("R2", "push before reset", 64'(ptr_word), 64'd7);
    rst_n = 1'b0;
    #2;
    check("R1", "ptr in reset", 64'(ptr_word), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    issue(3'd2, 3'd1, 64'd0);
    check("R1", "tags empty after reset", 64'(rsp_empty_fault), 64'd1);

    summary();
    $finish;
  end
endmodule